// File: doc/BRIEF.md
# Hinted Branch Target Predictor

This block sits in the fetch stage of a pipelined core. For each fetch address it answers three questions: is a branch known at this address, is it predicted taken, and what is its target. A small direct-mapped table holds what the block has learned. Each slot is chosen by a few low address bits and keeps a tag made of the remaining upper bits, a target address and a two-bit saturating direction counter.

Storage is spent only on branches that have been taken at least once, or that the instruction encoding marks as likely taken. A branch that has only ever fallen through never gets a slot, so it looks the same as straight-line code. When the table has no slot for the fetch address, a static rule built from predecode information decides instead. A backward target suggests a loop and is predicted taken. A forward target is predicted not-taken unless the encoding carries the taken hint. A hinted branch that misses is written into the table at once, so it does not have to be mispredicted first.

The execute stage reports each resolved branch on a resolve port. A hit moves the counter one step toward the outcome and corrects the stored target. A taken branch that misses gets a new slot.

Top module: `hinted_bpred`

## Requirements
- R1: A synchronous reset makes every slot invalid, so every lookup after reset misses (`pred_hit_o` = 0).
- R2: A resolved not-taken branch whose address misses creates no slot and leaves the slot already at that index unchanged.
- R3: On a miss, a non-branch, or a branch whose predecoded target is not below the fetch address and which carries no hint, is predicted not-taken.
- R4: On a miss, a branch whose predecoded target is below the fetch address (unsigned compare) is predicted taken, with `pred_target_o` equal to that target, and no slot is created for it.
- R5: A resolved taken branch that misses is written into the slot at index PC[5:2] with tag PC[31:6], the actual target, and counter value 2 (weakly taken).
- R6: The counter codes are 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. A hit predicts taken when the counter's upper bit is 1. Each resolve that hits moves the counter one step toward the outcome, and the counter saturates at 0 and at 3.
- R7: A resolved taken branch that hits replaces the stored target with the actual target. A resolved not-taken branch leaves the stored target as it is.
- R8: A lookup that misses on a branch carrying the taken hint is predicted taken with the predecoded target in the same cycle. At the next clock edge the branch is installed with counter value 2.
- R9: A hit needs a valid slot whose tag equals PC[31:6] in full. An address that shares the index but differs in the tag misses.
- R10: A lookup is combinational and returns the table as it stood before the current cycle's writes. When a resolve write and a hint install target the same index in the same cycle, the resolve write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fetch_pc_i | input | 32 | Fetch address being predicted |
| pre_branch_i | input | 1 | Predecode: the word at the fetch address is a conditional branch |
| pre_hint_i | input | 1 | Predecode: the branch carries the taken hint |
| pre_target_i | input | 32 | Predecode: the branch's direct target |
| pred_hit_o | output | 1 | A table slot matches the fetch address |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_target_o | output | 32 | Predicted target: stored target on a hit, predecoded target on a miss |
| res_valid_i | input | 1 | A resolved branch is reported this cycle |
| res_pc_i | input | 32 | Address of the resolved branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| res_target_i | input | 32 | Actual target of the resolved branch |

## Verification
The bench walks one slot through the whole counter range and checks the prediction after every step. A counter that wraps instead of saturating flips the prediction right after a saturating step. A not-taken resolve that misses is applied to an index that already holds another branch, so a design that allocates or evicts on a fall-through loses the resident branch. A same-cycle resolve and lookup on one address show whether reads bypass writes, and a same-cycle hint install and resolve on one index show which write wins. A hinted install is checked for its starting counter value by one not-taken resolve, which has to turn the prediction to not-taken.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam logic [1:0] CTR_SNT = 2'd0;
    localparam logic [1:0] CTR_WNT = 2'd1;
    localparam logic [1:0] CTR_WT  = 2'd2;
    localparam logic [1:0] CTR_ST  = 2'd3;

    // One saturating step toward the resolved outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_ST) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_SNT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/hbp_table.sv
module hbp_table #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int TAG_W = 26
) (
    input  logic             clk_i,
    input  logic             rst_i,
    // fetch-side read
    input  logic [IDX_W-1:0] f_idx_i,
    output logic             f_valid_o,
    output logic [TAG_W-1:0] f_tag_o,
    output logic [PC_W-1:0]  f_tgt_o,
    output logic [1:0]       f_ctr_o,
    // resolve-side read
    input  logic [IDX_W-1:0] r_idx_i,
    output logic             r_valid_o,
    output logic [TAG_W-1:0] r_tag_o,
    output logic [PC_W-1:0]  r_tgt_o,
    output logic [1:0]       r_ctr_o,
    // hint install write
    input  logic             ins_we_i,
    input  logic [TAG_W-1:0] ins_tag_i,
    input  logic [PC_W-1:0]  ins_tgt_i,
    // resolve write (wins over install)
    input  logic             res_we_i,
    input  logic [TAG_W-1:0] res_tag_i,
    input  logic [PC_W-1:0]  res_tgt_i,
    input  logic [1:0]       res_ctr_i
);
    import hbp_pkg::*;

    localparam int SLOTS = 1 << IDX_W;

    typedef struct packed {
        logic [SLOTS-1:0]            valid;
        logic [SLOTS-1:0][TAG_W-1:0] tag;
        logic [SLOTS-1:0][PC_W-1:0]  tgt;
        logic [SLOTS-1:0][1:0]       ctr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (ins_we_i) begin
            tbl_d.valid[f_idx_i] = 1'b1;
            tbl_d.tag[f_idx_i]   = ins_tag_i;
            tbl_d.tgt[f_idx_i]   = ins_tgt_i;
            tbl_d.ctr[f_idx_i]   = CTR_WT;
        end
        if (res_we_i) begin
            tbl_d.valid[r_idx_i] = 1'b1;
            tbl_d.tag[r_idx_i]   = res_tag_i;
            tbl_d.tgt[r_idx_i]   = res_tgt_i;
            tbl_d.ctr[r_idx_i]   = res_ctr_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tbl_q.valid <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign f_valid_o = tbl_q.valid[f_idx_i];
    assign f_tag_o   = tbl_q.tag[f_idx_i];
    assign f_tgt_o   = tbl_q.tgt[f_idx_i];
    assign f_ctr_o   = tbl_q.ctr[f_idx_i];
    assign r_valid_o = tbl_q.valid[r_idx_i];
    assign r_tag_o   = tbl_q.tag[r_idx_i];
    assign r_tgt_o   = tbl_q.tgt[r_idx_i];
    assign r_ctr_o   = tbl_q.ctr[r_idx_i];

    // R1: reset leaves no valid slot behind
    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_i |=> (tbl_q.valid == '0));

    // R5: a resolve write leaves its slot valid with the written target
    assert_res_write_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        res_we_i |=> (tbl_q.valid[$past(r_idx_i)] && tbl_q.tgt[$past(r_idx_i)] == $past(res_tgt_i)));

    // R8: an install that no resolve overrides starts weakly taken
    assert_install_wt_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (ins_we_i && !(res_we_i && r_idx_i == f_idx_i)) |=> (tbl_q.ctr[$past(f_idx_i)] == CTR_WT));

endmodule

// File: rtl/hbp_lookup.sv
module hbp_lookup #(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [PC_W-1:0]  fetch_pc_i,
    input  logic [TAG_W-1:0] fetch_tag_i,
    input  logic             pre_branch_i,
    input  logic             pre_hint_i,
    input  logic [PC_W-1:0]  pre_target_i,
    input  logic             e_valid_i,
    input  logic [TAG_W-1:0] e_tag_i,
    input  logic [PC_W-1:0]  e_tgt_i,
    input  logic [1:0]       e_ctr_i,
    output logic             hit_o,
    output logic             taken_o,
    output logic [PC_W-1:0]  target_o,
    output logic             ins_we_o
);
    logic backward;

    always_comb begin
        hit_o    = e_valid_i && (e_tag_i == fetch_tag_i);
        backward = pre_target_i < fetch_pc_i;
        if (hit_o) begin
            taken_o  = e_ctr_i[1];
            target_o = e_tgt_i;
        end else begin
            taken_o  = pre_branch_i && (pre_hint_i || backward);
            target_o = pre_target_i;
        end
        ins_we_o = !hit_o && pre_branch_i && pre_hint_i;
    end

    // R4: a backward branch that misses is predicted taken
    assert_backward_taken_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hit_o && pre_branch_i && (pre_target_i < fetch_pc_i)) |-> taken_o);

    // R8: a hinted miss is predicted taken and installed
    assert_hint_install_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hit_o && pre_branch_i && pre_hint_i) |-> (taken_o && ins_we_o));

    // R3: a non-branch that misses is never predicted taken
    assert_nonbranch_nt_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!hit_o && !pre_branch_i) |-> !taken_o);

endmodule

// File: rtl/hbp_resolve.sv
module hbp_resolve #(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             res_valid_i,
    input  logic [TAG_W-1:0] res_tag_i,
    input  logic             res_taken_i,
    input  logic [PC_W-1:0]  res_target_i,
    input  logic             e_valid_i,
    input  logic [TAG_W-1:0] e_tag_i,
    input  logic [PC_W-1:0]  e_tgt_i,
    input  logic [1:0]       e_ctr_i,
    output logic             we_o,
    output logic [PC_W-1:0]  tgt_o,
    output logic [1:0]       ctr_o
);
    import hbp_pkg::*;

    logic hit;

    always_comb begin
        hit   = e_valid_i && (e_tag_i == res_tag_i);
        we_o  = 1'b0;
        tgt_o = e_tgt_i;
        ctr_o = e_ctr_i;
        if (res_valid_i) begin
            if (hit) begin
                we_o  = 1'b1;
                ctr_o = ctr_step(e_ctr_i, res_taken_i);
                if (res_taken_i && (e_tgt_i != res_target_i)) tgt_o = res_target_i;
            end else if (res_taken_i) begin
                we_o  = 1'b1;
                tgt_o = res_target_i;
                ctr_o = CTR_WT;
            end
        end
    end

    // R2: a not-taken branch with no slot never writes
    assert_nt_miss_no_alloc_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_i && !hit && !res_taken_i) |-> !we_o);

    // R6: saturation at both ends
    assert_ctr_sat_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_i && hit && (e_ctr_i == {2{res_taken_i}})) |-> (ctr_o == e_ctr_i));

    // R7: a not-taken resolve keeps the stored target
    assert_nt_keeps_tgt_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_i && hit && !res_taken_i) |-> (tgt_o == e_tgt_i));

endmodule

// File: rtl/hinted_bpred.sv
module hinted_bpred #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [PC_W-1:0] fetch_pc_i,
    input  logic            pre_branch_i,
    input  logic            pre_hint_i,
    input  logic [PC_W-1:0] pre_target_i,
    output logic            pred_hit_o,
    output logic            pred_taken_o,
    output logic [PC_W-1:0] pred_target_o,
    input  logic            res_valid_i,
    input  logic [PC_W-1:0] res_pc_i,
    input  logic            res_taken_i,
    input  logic [PC_W-1:0] res_target_i
);
    localparam int OFS_W = 2;
    localparam int TAG_W = PC_W - IDX_W - OFS_W;

    logic [IDX_W-1:0] f_idx, r_idx;
    logic [TAG_W-1:0] f_tag, r_tag;
    logic [OFS_W-1:0] unused_res_lo;

    assign f_idx         = fetch_pc_i[OFS_W +: IDX_W];
    assign f_tag         = fetch_pc_i[PC_W-1 -: TAG_W];
    assign r_idx         = res_pc_i[OFS_W +: IDX_W];
    assign r_tag         = res_pc_i[PC_W-1 -: TAG_W];
    assign unused_res_lo = res_pc_i[OFS_W-1:0];

    logic             fe_valid, re_valid;
    logic [TAG_W-1:0] fe_tag, re_tag;
    logic [PC_W-1:0]  fe_tgt, re_tgt;
    logic [1:0]       fe_ctr, re_ctr;
    logic             ins_we, res_we;
    logic [PC_W-1:0]  res_wtgt;
    logic [1:0]       res_wctr;

    hbp_table #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .f_idx_i   (f_idx),
        .f_valid_o (fe_valid),
        .f_tag_o   (fe_tag),
        .f_tgt_o   (fe_tgt),
        .f_ctr_o   (fe_ctr),
        .r_idx_i   (r_idx),
        .r_valid_o (re_valid),
        .r_tag_o   (re_tag),
        .r_tgt_o   (re_tgt),
        .r_ctr_o   (re_ctr),
        .ins_we_i  (ins_we),
        .ins_tag_i (f_tag),
        .ins_tgt_i (pre_target_i),
        .res_we_i  (res_we),
        .res_tag_i (r_tag),
        .res_tgt_i (res_wtgt),
        .res_ctr_i (res_wctr)
    );

    hbp_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_lookup (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .fetch_pc_i   (fetch_pc_i),
        .fetch_tag_i  (f_tag),
        .pre_branch_i (pre_branch_i),
        .pre_hint_i   (pre_hint_i),
        .pre_target_i (pre_target_i),
        .e_valid_i    (fe_valid),
        .e_tag_i      (fe_tag),
        .e_tgt_i      (fe_tgt),
        .e_ctr_i      (fe_ctr),
        .hit_o        (pred_hit_o),
        .taken_o      (pred_taken_o),
        .target_o     (pred_target_o),
        .ins_we_o     (ins_we)
    );

    hbp_resolve #(.PC_W(PC_W), .TAG_W(TAG_W)) u_resolve (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .res_valid_i  (res_valid_i),
        .res_tag_i    (r_tag),
        .res_taken_i  (res_taken_i),
        .res_target_i (res_target_i),
        .e_valid_i    (re_valid),
        .e_tag_i      (re_tag),
        .e_tgt_i      (re_tgt),
        .e_ctr_i      (re_ctr),
        .we_o         (res_we),
        .tgt_o        (res_wtgt),
        .ctr_o        (res_wctr)
    );

endmodule

// File: tb/hinted_bpred_tb.sv
module hinted_bpred_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] fetch_pc, pre_target, res_pc, res_target, pred_target;
    logic        pre_branch, pre_hint, res_valid, res_taken, pred_hit, pred_taken;

    always #(CLK_PERIOD/2) clk = ~clk;

    hinted_bpred u_dut (
        .clk_i(clk), .rst_i(rst),
        .fetch_pc_i(fetch_pc), .pre_branch_i(pre_branch), .pre_hint_i(pre_hint),
        .pre_target_i(pre_target),
        .pred_hit_o(pred_hit), .pred_taken_o(pred_taken), .pred_target_o(pred_target),
        .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken),
        .res_target_i(res_target)
    );

    typedef struct {
        bit          active;
        bit          hit;
        bit          taken;
        bit          chk_tgt;
        logic [31:0] tgt;
        string       name;
    } exp_t;

    exp_t q[$];
    event look_ev;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // monitor: pops one expected item per cycle and compares
    always @(look_ev) begin
        exp_t e;
        #1;
        e = q.pop_front();
        if (e.active) begin
            checks++;
            if (pred_hit !== e.hit || pred_taken !== e.taken ||
                (e.chk_tgt && pred_target !== e.tgt)) begin
                errors++;
                $display("FAIL %s: hit/taken/target actual %0b/%0b/%h expected %0b/%0b/%h",
                         e.name, pred_hit, pred_taken, pred_target, e.hit, e.taken, e.tgt);
            end
        end
    end

    // driver: one cycle of lookup plus optional resolve
    task automatic cyc(input logic [31:0] pc, input bit br, input bit hint, input logic [31:0] ptgt,
                       input bit rv, input logic [31:0] rpc, input bit rtk, input logic [31:0] rtgt,
                       input bit act, input bit eh, input bit et, input bit ct,
                       input logic [31:0] etgt, input string name);
        exp_t e;
        @(negedge clk);
        fetch_pc = pc; pre_branch = br; pre_hint = hint; pre_target = ptgt;
        res_valid = rv; res_pc = rpc; res_taken = rtk; res_target = rtgt;
        e.active = act; e.hit = eh; e.taken = et; e.chk_tgt = ct; e.tgt = etgt; e.name = name;
        q.push_back(e);
        -> look_ev;
    endtask

    task automatic look(input logic [31:0] pc, input bit br, input bit hint, input logic [31:0] ptgt,
                        input bit eh, input bit et, input bit ct, input logic [31:0] etgt,
                        input string name);
        cyc(pc, br, hint, ptgt, 0, 0, 0, 0, 1, eh, et, ct, etgt, name);
    endtask

    task automatic resolve(input logic [31:0] rpc, input bit rtk, input logic [31:0] rtgt);
        cyc(32'h0, 0, 0, 0, 1, rpc, rtk, rtgt, 0, 0, 0, 0, 0, "none");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; fetch_pc = 0; pre_branch = 0; pre_hint = 0; pre_target = 0;
        res_valid = 0; res_pc = 0; res_taken = 0; res_target = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: empty table after reset
        look(32'h0000_0100, 0, 0, 0, 0, 0, 0, 0, "R1 reset miss");
        // R3: forward branch, no hint
        look(32'h0000_1000, 1, 0, 32'h1040, 0, 0, 1, 32'h1040, "R3 forward miss");
        // R4: backward branch predicted taken, not installed
        look(32'h0000_1004, 1, 0, 32'h0F00, 0, 1, 1, 32'h0F00, "R4 backward miss");
        look(32'h0000_1004, 0, 0, 0, 0, 0, 0, 0, "R4 backward not installed");

        // R2: not-taken miss allocates nothing
        resolve(32'h0000_1008, 0, 32'h1080);
        look(32'h0000_1008, 0, 0, 0, 0, 0, 0, 0, "R2 no alloc on fall-through");
        // R2: resident slot survives a not-taken miss at the same index
        resolve(32'h0000_2008, 1, 32'h2200);
        resolve(32'h0000_3008, 0, 32'h3300);
        look(32'h0000_2008, 0, 0, 0, 1, 1, 1, 32'h2200, "R2 resident kept");
        look(32'h0000_3008, 0, 0, 0, 0, 0, 0, 0, "R2 alias still absent");

        // R5: taken miss allocates weakly taken
        resolve(32'h0000_1010, 1, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 1, 1, 32'h1100, "R5 alloc weakly taken");
        // R6: counter walk, 2 -> 1 -> 0 -> 0 -> 1 -> 2 -> 3 -> 3 -> 2 -> 1
        resolve(32'h0000_1010, 0, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 0, 0, 0, "R6 ctr 1");
        resolve(32'h0000_1010, 0, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 0, 0, 0, "R6 ctr 0");
        resolve(32'h0000_1010, 0, 32'h1100);
        resolve(32'h0000_1010, 1, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 0, 0, 0, "R6 sat low then 1");
        resolve(32'h0000_1010, 1, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 1, 0, 0, "R6 ctr 2 after low sat");
        resolve(32'h0000_1010, 1, 32'h1100);
        resolve(32'h0000_1010, 1, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 1, 0, 0, "R6 sat high");
        resolve(32'h0000_1010, 0, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 1, 0, 0, "R6 ctr 2 from 3");
        resolve(32'h0000_1010, 0, 32'h1100);
        look(32'h0000_1010, 0, 0, 0, 1, 0, 0, 0, "R6 ctr 1 from 2");

        // R7: taken replaces target, not-taken keeps it
        resolve(32'h0000_1010, 1, 32'h1200);
        look(32'h0000_1010, 0, 0, 0, 1, 1, 1, 32'h1200, "R7 target replaced");
        resolve(32'h0000_1010, 0, 32'h1999);
        look(32'h0000_1010, 0, 0, 0, 1, 0, 1, 32'h1200, "R7 target kept on not-taken");

        // R9: same index, different tag misses
        look(32'h0000_1050, 0, 0, 0, 0, 0, 0, 0, "R9 tag mismatch");

        // R8: hinted forward branch predicted taken and installed at 2
        look(32'h0000_1020, 1, 1, 32'h1080, 0, 1, 1, 32'h1080, "R8 hint predicted taken");
        look(32'h0000_1020, 0, 0, 0, 1, 1, 1, 32'h1080, "R8 hint installed");
        resolve(32'h0000_1020, 0, 32'h1080);
        look(32'h0000_1020, 0, 0, 0, 1, 0, 0, 0, "R8 install began weakly taken");

        // R10: same-cycle lookup sees pre-update contents
        cyc(32'h0000_1030, 0, 0, 0, 1, 32'h0000_1030, 1, 32'h1300,
            1, 0, 0, 0, 0, "R10 lookup before write");
        look(32'h0000_1030, 0, 0, 0, 1, 1, 1, 32'h1300, "R10 write visible next cycle");
        // R10: resolve wins over a same-index hint install
        cyc(32'h0000_1040, 1, 1, 32'h1400, 1, 32'h0000_1040, 1, 32'h1444,
            1, 0, 1, 1, 32'h1400, "R10 hint miss same cycle");
        look(32'h0000_1040, 0, 0, 0, 1, 1, 1, 32'h1444, "R10 resolve write wins");

        // R1: reset again clears learned slots
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        look(32'h0000_1010, 0, 0, 0, 0, 0, 0, 0, "R1 reset clears slot");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule